// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor. One 8-bit accumulator is the only working register. A program counter, an instruction register, a memory address register and a memory data register surround it. Each instruction takes several clock cycles. The core first fetches the instruction word at the program counter and decodes it. Where the instruction needs an operand, the core then fetches it. Last, the core executes the instruction and either advances or redirects the program counter.

The core connects to an external 32-word synchronous memory. It drives the address from its address register and the write data from its data register. A read returns data one cycle after the address is presented. At reset the program counter takes the value on a start-address input. A halted output reports that a stop instruction has been reached. From then on the core holds its state until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: An instruction word holds its opcode in bits [7:5] and a memory address in bits [4:0]. The opcode codes are: 3'b000 stop, 3'b001 load, 3'b010 store, 3'b011 add, 3'b100 subtract, 3'b101 jump, 3'b110 jump-if-zero, 3'b111 jump-if-positive.
- R2: While reset is low, halted_o and mem_we_o are 0 and the accumulator is cleared to 0. At the first clock edge after reset is released, mem_addr_o takes the value of start_addr_i.
- R3: Load copies the memory word at the address field into the accumulator, then the program counter moves to the next word.
- R4: Add sets the accumulator to accumulator plus the memory operand, modulo 256. Any carry out is dropped.
- R5: Subtract sets the accumulator to accumulator minus the memory operand, modulo 256.
- R6: Store writes the accumulator to the address field. mem_we_o is high for exactly one cycle, with mem_addr_o and mem_wdata_o valid during that cycle.
- R7: Jump always loads the program counter from the address field. Instructions between the jump and its target are not executed.
- R8: Jump-if-zero loads the program counter from the address field only when the accumulator is 0. Otherwise the program counter moves to the next word.
- R9: Jump-if-positive is taken only when accumulator bit 7 is 0 and the accumulator is nonzero.
- R10: The program counter counts modulo 32, so the word after address 31 is fetched from address 0.
- R11: Once the stop instruction has executed, halted_o stays high. mem_we_o then stays low, and mem_addr_o and mem_wdata_o hold their values until reset.
- R12: A read returns data one cycle after the address is presented. Each instruction takes a fixed number of clock edges: load, add and subtract take 8, store takes 6, every jump (taken or not) takes 5, and stop reaches halted_o after 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | ADDR_W | Program counter value loaded during reset |
| mem_addr_o | output | ADDR_W | Memory address, driven from the address register |
| mem_wdata_o | output | DATA_W | Memory write data, driven from the data register |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the address |
| mem_we_o | output | 1 | Memory write enable |
| halted_o | output | 1 | High while the core is stopped |

## Verification
The bench builds the core with its default widths: 8-bit data and 5-bit addresses. With these widths the whole 32-word space fits in a bench array. A program can therefore sit across the top address and wrap to word 0, and every opcode code can be placed directly in memory. An instruction-level model in the bench runs each program. From it the bench predicts every store (address and data), the exact number of edges to halt, and the final memory contents. The chosen accumulator values test both sides of every jump condition: zero, 0x01, 0x7F and 0x80. The arithmetic operands are chosen so that add produces a carry and subtract borrows.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_STOP  = 3'b000,
    OP_LOAD  = 3'b001,
    OP_STORE = 3'b010,
    OP_ADD   = 3'b011,
    OP_SUB   = 3'b100,
    OP_JMP   = 3'b101,
    OP_JZ    = 3'b110,
    OP_JP    = 3'b111
  } opcode_e;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_WAIT,
    ST_F_READ,
    ST_DECODE,
    ST_ADDR,
    ST_O_WAIT,
    ST_O_READ,
    ST_EXEC,
    ST_WRITE,
    ST_STOP
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mdr_from_mem;
    logic    mdr_from_acc;
    logic    ir_ld;
    logic    acc_ld;
    logic    pc_inc;
    logic    pc_jump;
    logic    mem_we;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              neg_o
);
  // result width is DATA_W: carry and borrow are dropped
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = acc_i + opnd_i;
      ALU_SUB: res_o = acc_i - opnd_i;
      default: res_o = opnd_i;
    endcase
  end

  assign zero_o = (acc_i == '0);
  assign neg_o  = acc_i[DATA_W-1];
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            acc_zero_i,
  input  logic            acc_neg_i,
  output ctrl_t           ctrl_o,
  output logic            halted_o
);
  state_e  state_q, state_d;
  opcode_e op;
  logic    take_jz, take_jp;

  assign op      = opcode_e'(op_i);
  assign take_jz = acc_zero_i;
  assign take_jp = !acc_neg_i && !acc_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    unique case (state_q)
      ST_F_ADDR: begin
        ctrl_o.mar_from_pc = 1'b1;
        state_d = ST_F_WAIT;
      end
      ST_F_WAIT: state_d = ST_F_READ;   // memory read latency
      ST_F_READ: begin
        ctrl_o.mdr_from_mem = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl_o.ir_ld = 1'b1;
        state_d = ST_ADDR;
      end
      ST_ADDR: begin
        unique case (op)
          OP_STOP: state_d = ST_STOP;
          OP_LOAD, OP_ADD, OP_SUB: begin
            ctrl_o.mar_from_ir = 1'b1;
            state_d = ST_O_WAIT;
          end
          OP_STORE: begin
            ctrl_o.mar_from_ir  = 1'b1;
            ctrl_o.mdr_from_acc = 1'b1;
            state_d = ST_WRITE;
          end
          OP_JMP: begin
            ctrl_o.pc_jump = 1'b1;
            state_d = ST_F_ADDR;
          end
          OP_JZ: begin
            ctrl_o.pc_jump = take_jz;
            ctrl_o.pc_inc  = !take_jz;
            state_d = ST_F_ADDR;
          end
          default: begin
            ctrl_o.pc_jump = take_jp;
            ctrl_o.pc_inc  = !take_jp;
            state_d = ST_F_ADDR;
          end
        endcase
      end
      ST_O_WAIT: state_d = ST_O_READ;
      ST_O_READ: begin
        ctrl_o.mdr_from_mem = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        ctrl_o.acc_ld = 1'b1;
        ctrl_o.pc_inc = 1'b1;
        unique case (op)
          OP_ADD:  ctrl_o.alu_op = ALU_ADD;
          OP_SUB:  ctrl_o.alu_op = ALU_SUB;
          default: ctrl_o.alu_op = ALU_PASS;
        endcase
        state_d = ST_F_ADDR;
      end
      ST_WRITE: begin
        ctrl_o.mem_we = 1'b1;
        ctrl_o.pc_inc = 1'b1;
        state_d = ST_F_ADDR;
      end
      ST_STOP: state_d = ST_STOP;
      default: state_d = ST_F_ADDR;
    endcase
  end

  assign halted_o = (state_q == ST_STOP);
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_res_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];

  // PC wraps naturally at 2**ADDR_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pc_q <= start_addr_i;
    else if (ctrl_i.pc_jump) pc_q <= ir_addr;
    else if (ctrl_i.pc_inc)  pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mar_q <= '0;
    else if (ctrl_i.mar_from_pc) mar_q <= pc_q;
    else if (ctrl_i.mar_from_ir) mar_q <= ir_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mdr_q <= '0;
    else if (ctrl_i.mdr_from_mem) mdr_q <= mem_rdata_i;
    else if (ctrl_i.mdr_from_acc) mdr_q <= acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ir_q <= '0;
    else if (ctrl_i.ir_ld) ir_q <= mdr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_q <= '0;
    else if (ctrl_i.acc_ld) acc_q <= alu_res_i;
  end

  assign acc_o = acc_q;
  assign ir_o  = ir_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - acc_cpu_pkg::OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic              halted_o
);
  localparam int OP_LSB = DATA_W - OP_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] acc, ir, mdr, alu_res;
  logic [ADDR_W-1:0] mar;
  logic              acc_zero, acc_neg;

  acc_cpu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (ir[DATA_W-1:OP_LSB]),
    .acc_zero_i (acc_zero),
    .acc_neg_i  (acc_neg),
    .ctrl_o     (ctrl),
    .halted_o   (halted_o)
  );

  acc_cpu_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_addr_i (start_addr_i),
    .ctrl_i       (ctrl),
    .mem_rdata_i  (mem_rdata_i),
    .alu_res_i    (alu_res),
    .acc_o        (acc),
    .ir_o         (ir),
    .mar_o        (mar),
    .mdr_o        (mdr)
  );

  acc_cpu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .acc_i  (acc),
    .opnd_i (mdr),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (acc_zero),
    .neg_o  (acc_neg)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mdr;
  assign mem_we_o    = ctrl.mem_we;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_we_o,
  input logic              halted_o
);
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R6
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R11
  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o); // R11
  AST_HALT_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(mem_addr_o)); // R11
  AST_HALT_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(mem_wdata_o)); // R11
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!mem_we_o && !halted_o)); // R2
endmodule

bind acc_cpu_core acc_cpu_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .halted_o    (halted_o)
);

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, halted;

  logic [DW-1:0]   mem [WORDS];
  logic [DW-1:0]   ref_mem [WORDS];
  logic [AW+DW-1:0] exp_q [$];

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R6";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_addr_i (start_addr),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .mem_we_o     (mem_we),
    .halted_o     (halted)
  );

  // synchronous memory: one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected stores as the core writes
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(cur_req, "unexpected store", {19'd0, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
      end else begin
        chk(cur_req, "store addr/data R6", {19'd0, mem_addr, mem_wdata},
            {19'd0, exp_q.pop_front()});
      end
    end
  end

  function automatic logic [7:0] ins(logic [2:0] op, logic [4:0] a);
    return {op, a};
  endfunction

  task automatic fill(logic [7:0] v);
    for (int i = 0; i < WORDS; i++) mem[i] = v;
  endtask

  // instruction-level model: fills exp_q, returns edges to halt
  task automatic ref_run(input logic [4:0] start, output int cycles);
    logic [4:0] pc;
    logic [7:0] acc, w;
    pc = start; acc = 8'h00; cycles = 0;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = mem[i];
    for (int step = 0; step < 500; step++) begin
      w = ref_mem[pc];
      case (w[7:5])
        3'b000: begin cycles += 5; return; end
        3'b001: begin acc = ref_mem[w[4:0]]; cycles += 8; pc++; end
        3'b010: begin ref_mem[w[4:0]] = acc; exp_q.push_back({w[4:0], acc});
                      cycles += 6; pc++; end
        3'b011: begin acc = acc + ref_mem[w[4:0]]; cycles += 8; pc++; end
        3'b100: begin acc = acc - ref_mem[w[4:0]]; cycles += 8; pc++; end
        3'b101: begin pc = w[4:0]; cycles += 5; end
        3'b110: begin if (acc == 8'h00) pc = w[4:0]; else pc++; cycles += 5; end
        default: begin if (!acc[7] && acc != 8'h00) pc = w[4:0]; else pc++;
                       cycles += 5; end
      endcase
    end
  endtask

  task automatic run_prog(string req, logic [4:0] start);
    int exp_cyc, cyc;
    logic [AW-1:0] hold_addr;
    logic ok;
    cur_req = req;
    rst_n = 1'b0;
    start_addr = start;
    exp_q.delete();
    ref_run(start, exp_cyc);
    repeat (2) @(negedge clk);
    chk("R2", "halted_o in reset", {31'd0, halted}, 32'd0);
    chk("R2", "mem_we_o in reset", {31'd0, mem_we}, 32'd0);
    rst_n = 1'b1;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == 1) chk("R2", "first fetch address", {27'd0, mem_addr}, {27'd0, start});
      if (halted) break;
      if (cyc > 3000) begin
        chk(req, "run did not halt", 32'd0, 32'd1);
        break;
      end
    end
    chk({req, " R12"}, "edges to halt", cyc, exp_cyc);
    chk(req, "pending stores", exp_q.size(), 32'd0);
    hold_addr = mem_addr;
    ok = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (!halted || mem_addr !== hold_addr) ok = 1'b0;
    end
    chk("R11", "halt holds state", {31'd0, ok}, 32'd1);
  endtask

  initial begin
    // R1 R3 R4 R6: load 5, add -3, store 2
    fill(8'h00);
    mem[4] = ins(3'b001, 5'd8);
    mem[5] = ins(3'b011, 5'd9);
    mem[6] = ins(3'b010, 5'd10);
    mem[7] = ins(3'b000, 5'd0);
    mem[8] = 8'h05;
    mem[9] = 8'hFD;
    run_prog("R1 R3", 5'd4);
    chk("R4", "5 + -3", {24'd0, mem[10]}, 32'h02);

    // R4 carry dropped, R5 borrow
    fill(8'h00);
    mem[0] = ins(3'b001, 5'd20);
    mem[1] = ins(3'b011, 5'd21);
    mem[2] = ins(3'b010, 5'd22);
    mem[3] = ins(3'b100, 5'd23);
    mem[4] = ins(3'b010, 5'd24);
    mem[5] = ins(3'b000, 5'd0);
    mem[20] = 8'hF0; mem[21] = 8'h20; mem[23] = 8'h30;
    run_prog("R5", 5'd0);
    chk("R4", "F0+20 mod 256", {24'd0, mem[22]}, 32'h10);
    chk("R5", "10-30 mod 256", {24'd0, mem[24]}, 32'hE0);

    // R7 unconditional jump skips a store
    fill(8'hAA);
    mem[0] = ins(3'b101, 5'd5);
    mem[1] = ins(3'b010, 5'd30);
    mem[2] = ins(3'b000, 5'd0);
    mem[5] = ins(3'b001, 5'd20);
    mem[6] = ins(3'b010, 5'd21);
    mem[7] = ins(3'b000, 5'd0);
    mem[20] = 8'h3C;
    run_prog("R7", 5'd0);
    chk("R7", "skipped store untouched", {24'd0, mem[30]}, 32'hAA);
    chk("R7", "target executed", {24'd0, mem[21]}, 32'h3C);

    // R8 jump-if-zero, R2 accumulator cleared by reset
    fill(8'hAA);
    mem[0]  = ins(3'b110, 5'd3);
    mem[1]  = ins(3'b010, 5'd30);
    mem[2]  = ins(3'b000, 5'd0);
    mem[3]  = ins(3'b001, 5'd20);
    mem[4]  = ins(3'b110, 5'd2);
    mem[5]  = ins(3'b010, 5'd21);
    mem[6]  = ins(3'b001, 5'd22);
    mem[7]  = ins(3'b110, 5'd10);
    mem[8]  = ins(3'b010, 5'd30);
    mem[9]  = ins(3'b000, 5'd0);
    mem[10] = ins(3'b010, 5'd23);
    mem[11] = ins(3'b000, 5'd0);
    mem[20] = 8'h01; mem[22] = 8'h00; mem[23] = 8'h55;
    run_prog("R8", 5'd0);
    chk("R8", "not taken on nonzero", {24'd0, mem[21]}, 32'h01);
    chk("R8", "taken on zero", {24'd0, mem[23]}, 32'h00);
    chk("R8", "skipped store untouched", {24'd0, mem[30]}, 32'hAA);

    // R9 jump-if-positive on 01, 00, 80, 7F
    fill(8'hAA);
    mem[0]  = ins(3'b001, 5'd24);
    mem[1]  = ins(3'b111, 5'd3);
    mem[2]  = ins(3'b000, 5'd0);
    mem[3]  = ins(3'b001, 5'd25);
    mem[4]  = ins(3'b111, 5'd2);
    mem[5]  = ins(3'b001, 5'd26);
    mem[6]  = ins(3'b111, 5'd2);
    mem[7]  = ins(3'b001, 5'd27);
    mem[8]  = ins(3'b111, 5'd10);
    mem[9]  = ins(3'b000, 5'd0);
    mem[10] = ins(3'b010, 5'd28);
    mem[11] = ins(3'b000, 5'd0);
    mem[24] = 8'h01; mem[25] = 8'h00; mem[26] = 8'h80; mem[27] = 8'h7F;
    run_prog("R9", 5'd0);
    chk("R9", "path through all conditions", {24'd0, mem[28]}, 32'h7F);

    // R10 program counter wraps from 31 to 0
    fill(8'h00);
    mem[30] = ins(3'b001, 5'd20);
    mem[31] = ins(3'b010, 5'd21);
    mem[0]  = ins(3'b000, 5'd0);
    mem[20] = 8'hC3;
    run_prog("R10", 5'd30);
    chk("R10", "store after wrap", {24'd0, mem[21]}, 32'hC3);
    chk("R10", "stop fetched at 0", {27'd0, mem_addr}, 32'd0);

    // R11 immediate stop
    fill(8'h11);
    mem[17] = ins(3'b000, 5'd9);
    run_prog("R11", 5'd17);
    chk("R11", "address held at stop word", {27'd0, mem_addr}, 32'd17);
    chk("R11", "memory untouched", {24'd0, mem[9]}, 32'h11);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule